// File: doc/BRIEF.md
# Configurable SPI Serial Shift Engine

This block is a full-duplex SPI shift engine that runs as either host or client. A set of static configuration inputs selects its behaviour: enable, role, clock polarity, clock edge, sample phase, word length, select gating, framed mode and frame-sync placement. These inputs may only change while enable is low. In host mode the block divides the system clock to make the serial clock. It drives the data output and samples the data input. At the end of the word it returns the received word together with a one-cycle done strobe. In client mode it follows an external serial clock and an optional active-low select. Both inputs are brought into the system clock domain before their edges are used.

A word is started or queued through a one-cycle load strobe that carries the parallel transmit word. Data always travels most significant bit first. Words of 8 or 16 bits sit in the low bits of the parallel ports. In framed host mode a sync pulse one bit time wide is produced. It is either aligned with the first data bit, or placed in an extra clocked bit time just before that bit.

The controlling state machine has five states.
- ST_IDLE: host idle, or disabled.
- ST_LEAD: host frame-lead bit time.
- ST_SHIFT: host data bits.
- ST_CWAIT: client not selected.
- ST_CSEL: client selected.

Its transitions are:
- ST_IDLE goes to ST_LEAD on a load when framed mode is on with the early sync pulse.
- ST_IDLE goes to ST_SHIFT on any other host load.
- ST_LEAD goes to ST_SHIFT at the end of its bit time.
- ST_SHIFT goes back to ST_IDLE at the end of the last bit.
- ST_IDLE goes to ST_CWAIT when the role is client.
- ST_CWAIT goes to ST_CSEL when the client is selected.
- ST_CSEL goes back to ST_CWAIT on deselect.
- Dropping enable forces ST_IDLE from any state.

Top module: `spi_shift_engine`

## Requirements
- R1: Word length is 32 bits when mode32=1, otherwise 16 bits when mode16=1, otherwise 8 bits. A shorter word uses the low bits of tx_data and rx_data, and the unused upper bits of rx_data read 0.
- R2: Data is sent MSB first on sdo. In host mode each bit lasts 2*H system cycles, where H = div, or 1 when div = 0. sdo holds a bit for its whole bit time, starting the cycle after the load strobe is taken.
- R3: Whenever no host transfer is running, including in client mode, sck_o sits at its idle level. The idle level is high when cpol=1 and low when cpol=0.
- R4: During a host bit time, sck_o is at its idle level for the first H cycles when cke=1 and at its active level when cke=0. It takes the opposite level for the second H cycles, so data changes on the active-to-idle edge when cke=1 and on the idle-to-active edge when cke=0.
- R5: In host mode with smp=0, sdi is captured at the middle of each bit time, on the last cycle of the first half. With smp=1 it is captured on the last cycle of the bit time.
- R6: In client mode, sdi is captured at the clock edge that starts the second half of a bit, whatever the value of smp. That is the idle-to-active edge when cke=1 and the active-to-idle edge when cke=0. The client's next sdo bit follows the edge that starts each later bit.
- R7: rx_done is high for exactly one cycle per word. In host mode it rises in the cycle right after the last bit time ends, with rx_data valid in that same cycle. In client mode it rises 3 cycles after the final capture edge appears on sck_i.
- R8: While en is low the engine is held reset. busy and rx_done stay low, rx_data reads 0, sck_o stays at its idle level, and dropping en in the middle of a transfer ends it without a done strobe.
- R9: In client mode with framed mode off and ssen=1, clock edges are ignored while ss_n_i is high, and deselecting restarts the bit count. With ssen=0, ss_n_i has no effect.
- R10: When frm_en=1, ssen is not used, so a client word completes even with ssen=1 and ss_n_i high.
- R11: In framed host mode, fsync_o is high for one bit time. With frm_edge=1 that bit time is the first data bit. With frm_edge=0 it is an extra bit time before the first data bit, during which sck_o toggles and sdo already shows the MSB.
- R12: busy is high for the whole host transfer. A load strobe that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low holds the engine reset |
| host | input | 1 | 1 = host role, 0 = client role |
| cpol | input | 1 | Serial clock idle level |
| cke | input | 1 | Clock edge select for data change |
| smp | input | 1 | Host sample phase: 0 mid-bit, 1 end of bit |
| mode32 | input | 1 | Select 32-bit words |
| mode16 | input | 1 | Select 16-bit words when mode32=0 |
| ssen | input | 1 | Client select gating enable |
| frm_en | input | 1 | Framed mode enable |
| frm_edge | input | 1 | Sync pulse on first bit (1) or one bit earlier (0) |
| div | input | DIVW | Serial clock half period in system cycles (0 treated as 1) |
| tx_data | input | 32 | Parallel word to transmit |
| tx_load | input | 1 | One-cycle load/start strobe |
| rx_data | output | 32 | Last received word |
| rx_done | output | 1 | One-cycle word-complete strobe |
| busy | output | 1 | Host transfer in progress |
| sck_i | input | 1 | Client serial clock input |
| sck_o | output | 1 | Host serial clock output |
| ss_n_i | input | 1 | Client select input, active low |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| fsync_o | output | 1 | Host frame sync output |

## Verification
In host mode, every output is due in the first cycle after the posedge that takes the load strobe. A behavioural model counts cycles from that edge and, on every falling clock edge, predicts sck_o, sdo, fsync_o, busy and rx_done from that count and H. It also drives sdi with a different bit in each half of a bit time, so the received word shows which sample point was used. In client mode the bench moves sck_i one cycle after a rising edge and expects rx_done exactly 3 cycles later, which covers two synchronizer flops and one action flop. It checks sdo eight cycles after each change edge and flips sdi six cycles after each capture edge, so a late capture would be seen.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int WMAX = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_CWAIT,
        ST_CSEL
    } eng_state_t;

    typedef struct packed {
        logic host;
        logic cpol;
        logic cke;
        logic smp;
        logic mode32;
        logic mode16;
        logic ssen;
        logic frm_en;
        logic frm_edge;
    } eng_cfg_t;

    function automatic logic [5:0] word_bits(input logic m32, input logic m16);
        if (m32)      return 6'd32;
        else if (m16) return 6'd16;
        else          return 6'd8;
    endfunction

    function automatic logic [WMAX-1:0] word_mask(input logic m32, input logic m16);
        if (m32)      return {WMAX{1'b1}};
        else if (m16) return {16'h0000, 16'hFFFF};
        else          return {24'h000000, 8'hFF};
    endfunction

    function automatic logic [WMAX-1:0] left_align(input logic [WMAX-1:0] w,
                                                   input logic m32, input logic m16);
        if (m32)      return w;
        else if (m16) return {w[15:0], 16'h0000};
        else          return {w[7:0], 24'h000000};
    endfunction

endpackage

// File: rtl/spi_halfdiv.sv
module spi_halfdiv #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    assign lim  = (div == '0) ? DIVW'(1) : div;
    assign tick = run && (cnt == lim - DIVW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIVW'(1);
    end

    // R2
    half_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim));

endmodule

// File: rtl/spi_insync.sv
module spi_insync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [STAGES:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stg <= '0;
        else if (clr)
            stg <= {(STAGES+1){din}};
        else
            stg <= {stg[STAGES-1:0], din};
    end

    assign dout  = stg[STAGES-1];
    assign dprev = stg[STAGES];

endmodule

// File: rtl/spi_eng_core.sv
module spi_eng_core
    import spi_eng_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  eng_cfg_t        cfg,
    input  logic [WMAX-1:0] tx_data,
    input  logic            tx_load,
    input  logic            tick,
    input  logic            sck_rise,
    input  logic            sck_fall,
    input  logic            ss_act,
    input  logic            sdi,
    output logic            run,
    output logic            sck_o,
    output logic            sdo_o,
    output logic            fsync_o,
    output logic            busy_o,
    output logic [WMAX-1:0] rx_data,
    output logic            rx_done
);
    eng_state_t      state, nxt;
    logic            half;
    logic [5:0]      bcnt;
    logic [5:0]      len;
    logic [WMAX-1:0] shreg;
    logic [WMAX-1:0] rxsr;
    logic [WMAX-1:0] rx_next;
    logic [WMAX-1:0] load_word;
    logic [WMAX-1:0] lmask;
    logic            sel;
    logic            act_edge, idle_edge, samp_edge, chg_edge;
    logic            last_bit;
    logic            lead_req;
    logic            host_lvl;

    assign len       = word_bits(cfg.mode32, cfg.mode16);
    assign lmask     = word_mask(cfg.mode32, cfg.mode16);
    assign load_word = left_align(tx_data, cfg.mode32, cfg.mode16);
    assign rx_next   = {rxsr[WMAX-2:0], sdi};
    assign last_bit  = (bcnt == len - 6'd1);
    assign lead_req  = cfg.frm_en && !cfg.frm_edge;
    assign sel       = (cfg.frm_en || !cfg.ssen) ? 1'b1 : ss_act;
    assign act_edge  = cfg.cpol ? sck_fall : sck_rise;
    assign idle_edge = cfg.cpol ? sck_rise : sck_fall;
    assign samp_edge = cfg.cke ? act_edge : idle_edge;
    assign chg_edge  = cfg.cke ? idle_edge : act_edge;
    assign host_lvl  = cfg.cpol ^ (cfg.cke ? half : ~half);
    assign sdo_o     = shreg[WMAX-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (!en)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!cfg.host)
                    nxt = ST_CWAIT;
                else if (tx_load)
                    nxt = lead_req ? ST_LEAD : ST_SHIFT;
            end
            ST_LEAD: begin
                if (tick && half)
                    nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick && half && last_bit)
                    nxt = ST_IDLE;
            end
            ST_CWAIT: begin
                if (sel)
                    nxt = ST_CSEL;
            end
            ST_CSEL: begin
                if (!sel)
                    nxt = ST_CWAIT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half    <= 1'b0;
            bcnt    <= '0;
            shreg   <= '0;
            rxsr    <= '0;
            rx_data <= '0;
            rx_done <= 1'b0;
        end else if (!en) begin
            half    <= 1'b0;
            bcnt    <= '0;
            shreg   <= '0;
            rxsr    <= '0;
            rx_data <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    half <= 1'b0;
                    bcnt <= '0;
                    if (cfg.host && tx_load) begin
                        shreg <= load_word;
                        rxsr  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick)
                        half <= ~half;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!half) begin
                            half <= 1'b1;
                            if (!cfg.smp)
                                rxsr <= rx_next;
                        end else begin
                            half <= 1'b0;
                            if (cfg.smp)
                                rxsr <= rx_next;
                            if (last_bit) begin
                                rx_done <= 1'b1;
                                rx_data <= lmask & (cfg.smp ? rx_next : rxsr);
                                bcnt    <= '0;
                            end else begin
                                bcnt  <= bcnt + 6'd1;
                                shreg <= {shreg[WMAX-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_CWAIT: begin
                    bcnt <= '0;
                    if (tx_load)
                        shreg <= load_word;
                end
                ST_CSEL: begin
                    if (!sel) begin
                        bcnt <= '0;
                    end else if (samp_edge) begin
                        rxsr <= rx_next;
                        if (last_bit) begin
                            bcnt    <= '0;
                            rx_done <= 1'b1;
                            rx_data <= lmask & rx_next;
                        end else begin
                            bcnt <= bcnt + 6'd1;
                        end
                    end else if (chg_edge && bcnt != '0) begin
                        shreg <= {shreg[WMAX-2:0], 1'b0};
                    end else if (tx_load && bcnt == '0) begin
                        shreg <= load_word;
                    end
                end
                default: begin
                    bcnt <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sck_o   = cfg.cpol;
        fsync_o = 1'b0;
        busy_o  = 1'b0;
        run     = 1'b0;
        unique case (state)
            ST_LEAD: begin
                busy_o  = 1'b1;
                run     = 1'b1;
                sck_o   = host_lvl;
                fsync_o = cfg.frm_en;
            end
            ST_SHIFT: begin
                busy_o  = 1'b1;
                run     = 1'b1;
                sck_o   = host_lvl;
                fsync_o = cfg.frm_en && cfg.frm_edge && (bcnt == '0);
            end
            default: begin
                sck_o = cfg.cpol;
            end
        endcase
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R8
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rx_done && !busy_o));

    // R12
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && busy_o && !tick) |=> $stable(shreg));

    // R4
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && busy_o && !tick) |=> $stable(sck_o));

    // R11
    fsync_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |-> busy_o);

    // R9
    deselect_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg.host && cfg.ssen && !cfg.frm_en && !ss_act) |=> !rx_done);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DIVW        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            host,
    input  logic            cpol,
    input  logic            cke,
    input  logic            smp,
    input  logic            mode32,
    input  logic            mode16,
    input  logic            ssen,
    input  logic            frm_en,
    input  logic            frm_edge,
    input  logic [DIVW-1:0] div,
    input  logic [WMAX-1:0] tx_data,
    input  logic            tx_load,
    output logic [WMAX-1:0] rx_data,
    output logic            rx_done,
    output logic            busy,
    input  logic            sck_i,
    output logic            sck_o,
    input  logic            ss_n_i,
    input  logic            sdi,
    output logic            sdo,
    output logic            fsync_o
);
    eng_cfg_t   cfg;
    logic       tick;
    logic       run;
    logic [1:0] pin_now, pin_prev;
    logic       sck_rise, sck_fall, ss_act;

    assign cfg = '{host: host, cpol: cpol, cke: cke, smp: smp, mode32: mode32,
                   mode16: mode16, ssen: ssen, frm_en: frm_en, frm_edge: frm_edge};

    spi_halfdiv #(.DIVW(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .tick  (tick)
    );

    spi_insync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .din   ({ss_n_i, sck_i}),
        .dout  (pin_now),
        .dprev (pin_prev)
    );

    assign sck_rise = pin_now[0] && !pin_prev[0];
    assign sck_fall = !pin_now[0] && pin_prev[0];
    assign ss_act   = !pin_now[1];

    spi_eng_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cfg       (cfg),
        .tx_data   (tx_data),
        .tx_load   (tx_load),
        .tick      (tick),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .ss_act    (ss_act),
        .sdi       (sdi),
        .run       (run),
        .sck_o     (sck_o),
        .sdo_o     (sdo),
        .fsync_o   (fsync_o),
        .busy_o    (busy),
        .rx_data   (rx_data),
        .rx_done   (rx_done)
    );

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == cpol));

endmodule

// File: tb/tb_spi_shift_engine.sv
`timescale 1ns/1ps
module tb_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        host = 1'b1, cpol = 1'b0, cke = 1'b1, smp = 1'b0;
    logic        mode32 = 1'b0, mode16 = 1'b0, ssen = 1'b0;
    logic        frm_en = 1'b0, frm_edge = 1'b0;
    logic [7:0]  div = 8'd2;
    logic [31:0] tx_data = '0;
    logic        tx_load = 1'b0;
    logic [31:0] rx_data;
    logic        rx_done, busy, sck_o, sdo, fsync_o;
    logic        sck_i = 1'b0, ss_n_i = 1'b1, sdi = 1'b0;

    spi_shift_engine dut (
        .clk(clk), .rst_n(rst_n), .en(en), .host(host), .cpol(cpol), .cke(cke),
        .smp(smp), .mode32(mode32), .mode16(mode16), .ssen(ssen), .frm_en(frm_en),
        .frm_edge(frm_edge), .div(div), .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_done(rx_done), .busy(busy), .sck_i(sck_i),
        .sck_o(sck_o), .ss_n_i(ss_n_i), .sdi(sdi), .sdo(sdo), .fsync_o(fsync_o)
    );

    always #2.5 clk = ~clk;

    integer n_cmp = 0, n_bad = 0;
    integer cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tg, cyc, act, exp);
        end
    endtask

    function automatic integer blen();
        if (mode32) return 32;
        else if (mode16) return 16;
        else return 8;
    endfunction

    function automatic logic [31:0] bmask();
        if (mode32) return 32'hFFFF_FFFF;
        else if (mode16) return 32'h0000_FFFF;
        else return 32'h0000_00FF;
    endfunction

    // host reference model state
    bit          mon_on = 0;
    bit          h_on = 0;
    integer      h_start = 0, h_stop = 32'h7FFF_FFFF;
    integer      h_len = 8, h_lead = 0;
    logic [31:0] h_tx, h_wa, h_wb;
    string       h_tag = "R1";
    string       q_tag = "R7";
    // client model state
    integer      c_done_cyc = -1;
    logic [31:0] c_rx = '0;
    string       c_tag = "R6";

    integer t, hh, tot, b, hf, d, ix;
    logic   e_sck;

    always @(negedge clk) begin
        if (mon_on) begin
            if (h_on && cyc >= h_stop) h_on = 0;
            if (host) begin
                if (h_on) begin
                    hh  = (div == 0) ? 1 : div;
                    t   = cyc - h_start;
                    tot = (h_len + h_lead) * 2 * hh;
                    if (t < tot) begin
                        b  = t / (2 * hh);
                        hf = (t / hh) % 2;
                        d  = b - h_lead;
                        ix = (d < 0) ? h_len - 1 : h_len - 1 - d;
                        e_sck = cpol ^ (cke ? hf[0] : ~hf[0]);
                        chk("R4", {31'd0, sck_o}, {31'd0, e_sck});
                        chk("R12", {31'd0, busy}, 32'd1);
                        chk("R11", {31'd0, fsync_o}, {31'd0, frm_en && (b == 0)});
                        chk("R2", {31'd0, sdo}, {31'd0, h_tx[ix]});
                        chk(q_tag, {31'd0, rx_done}, 32'd0);
                        if (d < 0) sdi = 1'b0;
                        else sdi = hf ? h_wb[ix] : h_wa[ix];
                    end else begin
                        chk("R7", {31'd0, rx_done}, 32'd1);
                        chk("R12", {31'd0, busy}, 32'd0);
                        chk("R3", {31'd0, sck_o}, {31'd0, cpol});
                        chk(h_tag, rx_data, (smp ? h_wb : h_wa) & bmask());
                        h_on = 0;
                    end
                end else begin
                    chk(q_tag, {31'd0, rx_done}, 32'd0);
                    chk(q_tag == "R8" ? "R8" : "R12", {31'd0, busy}, 32'd0);
                    chk("R3", {31'd0, sck_o}, {31'd0, cpol});
                    chk("R11", {31'd0, fsync_o}, 32'd0);
                end
            end else begin
                chk("R7", {31'd0, rx_done}, {31'd0, cyc == c_done_cyc});
                if (cyc == c_done_cyc) chk(c_tag, rx_data, c_rx);
                chk("R3", {31'd0, sck_o}, {31'd0, cpol});
                chk("R12", {31'd0, busy}, 32'd0);
            end
        end
    end

    task automatic step(input integer n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic dis;
        step(1); en = 1'b0; h_on = 0; step(2);
    endtask

    task automatic ena;
        step(1); en = 1'b1; step(3);
    endtask

    task automatic host_start(input logic [31:0] tx, input logic [31:0] wa,
                              input logic [31:0] wb, input string tg);
        step(1);
        tx_data = tx; tx_load = 1'b1;
        @(posedge clk); #1;
        tx_load = 1'b0;
        h_start = cyc; h_stop = 32'h7FFF_FFFF;
        h_len = blen(); h_lead = (frm_en && !frm_edge) ? 1 : 0;
        h_tx = tx & bmask(); h_wa = wa; h_wb = wb; h_tag = tg;
        h_on = 1;
    endtask

    task automatic host_wait;
        while (h_on) step(1);
        step(2);
    endtask

    task automatic client_word(input logic [31:0] tx, input logic [31:0] rx,
                               input bit exp_done, input string tg);
        integer L;
        logic lva, lvb;
        L = blen();
        lva = cke ? cpol : ~cpol;
        lvb = ~lva;
        step(1);
        tx_data = tx; tx_load = 1'b1;
        step(1);
        tx_load = 1'b0;
        step(2);
        for (int i = 0; i < L; i++) begin
            sck_i = lva; sdi = rx[L-1-i];
            step(8);
            if (exp_done) chk("R2", {31'd0, sdo}, {31'd0, tx[L-1-i]});
            sck_i = lvb;
            if (i == L - 1 && exp_done) begin
                c_done_cyc = cyc + 3; c_rx = rx & bmask(); c_tag = tg;
            end
            step(6);
            sdi = ~sdi;
            step(2);
        end
        sck_i = cpol;
        step(8);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // reset / disabled state
        @(negedge clk);
        chk("R8", {31'd0, rx_done}, 32'd0);
        chk("R8", {31'd0, busy}, 32'd0);
        chk("R8", rx_data, 32'd0);
        chk("R8", {31'd0, sck_o}, {31'd0, cpol});
        mon_on = 1;

        // R1 R5: 8-bit, mid sample
        host = 1; cpol = 0; cke = 1; smp = 0; mode32 = 0; mode16 = 0; div = 8'd2;
        ena;
        host_start(32'h0000_00A5, 32'h0000_003C, 32'h0000_00C3, "R5"); host_wait;
        // R5: end sample
        dis; smp = 1; ena;
        host_start(32'h0000_005A, 32'h0000_0096, 32'h0000_0069, "R5"); host_wait;
        // R1 R3 R4: 16-bit, cpol 1, cke 0
        dis; smp = 0; cpol = 1; cke = 0; mode16 = 1; div = 8'd3; ena;
        host_start(32'h0000_C3A1, 32'h0000_1234, 32'h0000_EDCB, "R1"); host_wait;
        // R1 R2: 32-bit, div 0 treated as 1
        dis; cpol = 0; cke = 0; smp = 1; mode32 = 1; div = 8'd0; ena;
        host_start(32'h8123_4567, 32'h0F0F_F0F0, 32'hDEAD_BEEF, "R1"); host_wait;
        // R11: framed, pulse with first bit
        dis; mode32 = 0; mode16 = 0; smp = 0; cke = 1; frm_en = 1; frm_edge = 1; div = 8'd2; ena;
        host_start(32'h0000_00E1, 32'h0000_0055, 32'h0000_00AA, "R11"); host_wait;
        // R11: framed, pulse one bit early
        dis; frm_edge = 0; div = 8'd1; ena;
        host_start(32'h0000_0077, 32'h0000_0081, 32'h0000_007E, "R11"); host_wait;
        // R12: load while busy ignored
        dis; frm_en = 0; div = 8'd2; ena;
        host_start(32'h0000_00B4, 32'h0000_0033, 32'h0000_00CC, "R12");
        step(5);
        tx_data = 32'h0000_004B; tx_load = 1'b1;
        step(1);
        tx_load = 1'b0;
        host_wait;
        // R8: drop enable mid-transfer
        host_start(32'h0000_00F0, 32'h0000_000F, 32'h0000_00F0, "R8");
        step(7);
        q_tag = "R8";
        en = 1'b0; h_stop = cyc + 1;
        step(40);
        q_tag = "R7";
        ena;
        host_start(32'h0000_0019, 32'h0000_0062, 32'h0000_009D, "R8"); host_wait;

        // client mode, R6: smp set yet mid capture
        dis; host = 0; cpol = 0; cke = 1; smp = 1; ssen = 1; ss_n_i = 1'b0; sck_i = 1'b0; ena;
        client_word(32'h0000_00C5, 32'h0000_0093, 1, "R6");
        // R6 R9: cke 0, cpol 1, 16-bit, select ignored with ssen 0
        dis; cpol = 1; cke = 0; mode16 = 1; ssen = 0; ss_n_i = 1'b1; sck_i = 1'b1; ena;
        client_word(32'h0000_A55A, 32'h0000_3C69, 1, "R9");
        // R9: gated while deselected, then selected word
        dis; mode16 = 0; cke = 1; cpol = 0; ssen = 1; ss_n_i = 1'b1; sck_i = 1'b0; ena;
        c_done_cyc = -1;
        client_word(32'h0000_00FF, 32'h0000_0011, 0, "R9");
        ss_n_i = 1'b0;
        step(4);
        client_word(32'h0000_0036, 32'h0000_00E7, 1, "R9");
        // R10: framed mode ignores select gating
        dis; frm_en = 1; frm_edge = 1; ss_n_i = 1'b1; ena;
        client_word(32'h0000_0048, 32'h0000_00B2, 1, "R10");
        step(5);

        mon_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule